// File: doc/BRIEF.md
# In-Order Dual-Issue Dispatch Stage

This block sits between instruction decode and three execution units: two integer units that each finish an instruction in a single cycle, and one floating-point unit with a three-stage, fully pipelined execute path that takes one new instruction per cycle. Decode hands over up to two instructions per cycle as an ordered pair. Each instruction carries a one-bit unit type and a sequence tag, and the block holds them in a small age-ordered slot store.

Every cycle the block looks at the held instructions from oldest to youngest. It sends each one to a free port of its kind and stops at the first one that cannot go out. Issue therefore stays strictly in program order across unit types. A floating-point instruction that is waiting for the single floating-point port also holds back every younger integer instruction, even when an integer unit is idle. When fewer than two slots are free, the block stops accepting from decode. A synchronous flush empties the store.

Top module: `dual_issue_dispatch`

## Requirements
- R1: After reset no issue port is valid and `dec_ready` is 1, because the slot store is empty.
- R2: `dec_ready` is 1 exactly when `flush` is 0 and at least two of the `DEPTH` slots (default 4) are free, counted before the current cycle's issue. A pair offered while `dec_ready` is 0 is not taken and never appears on an issue port.
- R3: Instructions issue in program order, scanning from the oldest held instruction and stopping at the first that cannot issue. The oldest held instruction always issues unless `flush` is 1, and a younger integer instruction behind a blocked floating-point instruction stays held.
- R4: Up to two integer instructions (type bit 0) issue per cycle. The older one goes on port `int0` and the younger on `int1`, and `int1_valid` is never 1 while `int0_valid` is 0.
- R5: At most one floating-point instruction (type bit 1) issues per cycle, on the `fp` port. When two are ready, the younger waits in the slot store.
- R6: An instruction accepted at a clock edge can appear on an issue port in the cycle that starts at that edge. It never appears in the cycle in which decode presents it.
- R7: While `flush` is 1, no issue port is valid and `dec_ready` is 0. After that edge the slot store is empty.
- R8: Lane 0 is the older lane. A `dec_valid` value of 2'b01 delivers one instruction and 2'b11 delivers two. The value 2'b10 (lane 1 without lane 0) delivers nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Synchronous clear of all held instructions |
| dec_valid | input | 2 | Per-lane valid from decode, lane 0 older |
| dec_is_fp | input | 2 | Per-lane unit type: 0 integer, 1 floating-point |
| dec_tag0 | input | TAG_W | Sequence tag of lane 0 |
| dec_tag1 | input | TAG_W | Sequence tag of lane 1 |
| dec_ready | output | 1 | Pair accepted at the next edge when high |
| int0_valid | output | 1 | Issue to integer unit 0 this cycle |
| int0_tag | output | TAG_W | Tag issued to integer unit 0 |
| int1_valid | output | 1 | Issue to integer unit 1 this cycle |
| int1_tag | output | TAG_W | Tag issued to integer unit 1 |
| fp_valid | output | 1 | Issue to the floating-point unit this cycle |
| fp_tag | output | TAG_W | Tag issued to the floating-point unit |

## Verification
The assertions check on every cycle the structural rules of issue. The slot store never overfills. The integer ports fill in order. A held instruction is always explained by a port that is already taken. The oldest instruction always leaves, and a flush always empties the store. Only the bench's scenarios can show which tag comes out in which cycle. That covers the one-cycle acceptance-to-issue timing, a younger integer instruction held behind a second floating-point instruction, a pair refused under backpressure, and a lone lane-1 valid being dropped. A reference queue model in the bench predicts these, and the bench compares against it each cycle under mixed random traffic.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

  parameter int unsigned TAG_W = 8;

  typedef int unsigned uint_t;

  typedef struct packed {
    logic             is_fp;
    logic [TAG_W-1:0] tag;
  } instr_t;

  // Circular index: base + off folded once into [0, depth)
  function automatic uint_t wrap_idx(uint_t base, uint_t off, uint_t depth);
    uint_t s;
    s = base + off;
    return (s >= depth) ? s - depth : s;
  endfunction

  // Number of instructions delivered by a lane-valid pattern (lane 0 must lead)
  function automatic logic [1:0] lane_count(logic [1:0] v);
    if (!v[0]) return 2'd0;
    return v[1] ? 2'd2 : 2'd1;
  endfunction

  // Free slots in a store of depth entries holding occ
  function automatic uint_t free_slots(uint_t occ, uint_t depth);
    return depth - occ;
  endfunction

endpackage

// File: rtl/dispatch_slots.sv
module dispatch_slots
  import dispatch_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic [1:0]              push_n,
  input  instr_t [1:0]            push_ent,
  input  logic [CW-1:0]           pop_n,
  output instr_t [DEPTH-1:0]      view,
  output logic [DEPTH-1:0]        view_vld,
  output logic [CW-1:0]           occ
);

  instr_t [DEPTH-1:0] mem;
  logic   [PW-1:0]    head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      occ  <= '0;
    end else if (flush) begin
      head <= '0;
      occ  <= '0;
    end else begin
      head <= PW'(wrap_idx(uint_t'(head), uint_t'(pop_n), DEPTH));
      occ  <= occ - pop_n + CW'(push_n);
    end
  end

  // Writes land after the current tail; popping never touches those slots
  always_ff @(posedge clk) begin
    if (!flush) begin
      for (int l = 0; l < 2; l++) begin
        if (uint_t'(l) < uint_t'(push_n))
          mem[wrap_idx(uint_t'(head), uint_t'(occ) + uint_t'(l), DEPTH)] <= push_ent[l];
      end
    end
  end

  // Age-ordered view: entry 0 is the oldest held instruction
  for (genvar g = 0; g < DEPTH; g++) begin : g_view
    assign view[g]     = mem[wrap_idx(uint_t'(head), uint_t'(g), DEPTH)];
    assign view_vld[g] = (CW'(g) < occ);
  end

  // R2
  property no_overflow_p;
    @(posedge clk) disable iff (!rst_n)
      (push_n != 2'd0) |-> (uint_t'(occ) + uint_t'(push_n) <= DEPTH);
  endproperty
  no_overflow_chk: assert property (no_overflow_p);

  // R7
  property flush_empties_p;
    @(posedge clk) disable iff (!rst_n)
      flush |=> (occ == '0);
  endproperty
  flush_empties_chk: assert property (flush_empties_p);

endmodule

// File: rtl/dispatch_pick.sv
module dispatch_pick
  import dispatch_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  instr_t [DEPTH-1:0]  view,
  input  logic [DEPTH-1:0]    view_vld,
  output logic [1:0]          int_vld,
  output instr_t [1:0]        int_ent,
  output logic                fp_vld,
  output instr_t              fp_ent,
  output logic [CW-1:0]       pop_n,
  output logic                held_by_fp,
  output logic                held_by_int
);

  logic [1:0] n_int;
  logic       stop;

  always_comb begin
    int_vld     = '0;
    int_ent     = '0;
    fp_vld      = 1'b0;
    fp_ent      = '0;
    pop_n       = '0;
    n_int       = '0;
    stop        = 1'b0;
    held_by_fp  = 1'b0;
    held_by_int = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!flush && view_vld[i] && !stop) begin
        if (!view[i].is_fp) begin
          if (n_int < 2'd2) begin
            int_vld[n_int[0]] = 1'b1;
            int_ent[n_int[0]] = view[i];
            n_int = n_int + 2'd1;
            pop_n = pop_n + CW'(1);
          end else begin
            stop        = 1'b1;
            held_by_int = 1'b1;
          end
        end else begin
          if (!fp_vld) begin
            fp_vld = 1'b1;
            fp_ent = view[i];
            pop_n  = pop_n + CW'(1);
          end else begin
            stop       = 1'b1;
            held_by_fp = 1'b1;
          end
        end
      end
    end
  end

  // R5
  property fp_hold_cause_p;
    @(posedge clk) disable iff (!rst_n)
      held_by_fp |-> fp_vld;
  endproperty
  fp_hold_cause_chk: assert property (fp_hold_cause_p);

  // R4
  property int_hold_cause_p;
    @(posedge clk) disable iff (!rst_n)
      held_by_int |-> (int_vld == 2'b11);
  endproperty
  int_hold_cause_chk: assert property (int_hold_cause_p);

  // R3
  property oldest_leaves_p;
    @(posedge clk) disable iff (!rst_n)
      (view_vld[0] && !flush) |-> (pop_n != '0);
  endproperty
  oldest_leaves_chk: assert property (oldest_leaves_p);

endmodule

// File: rtl/dual_issue_dispatch.sv
module dual_issue_dispatch
  import dispatch_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [1:0]       dec_valid,
  input  logic [1:0]       dec_is_fp,
  input  logic [TAG_W-1:0] dec_tag0,
  input  logic [TAG_W-1:0] dec_tag1,
  output logic             dec_ready,
  output logic             int0_valid,
  output logic [TAG_W-1:0] int0_tag,
  output logic             int1_valid,
  output logic [TAG_W-1:0] int1_tag,
  output logic             fp_valid,
  output logic [TAG_W-1:0] fp_tag
);

  instr_t [1:0]       push_ent;
  logic [1:0]         push_n;
  instr_t [DEPTH-1:0] view;
  logic [DEPTH-1:0]   view_vld;
  logic [CW-1:0]      occ;
  logic [CW-1:0]      pop_n;
  logic [1:0]         int_vld;
  instr_t [1:0]       int_ent;
  logic               fp_vld;
  instr_t             fp_ent;
  logic               held_by_fp;
  logic               held_by_int;

  assign push_ent[0] = '{is_fp: dec_is_fp[0], tag: dec_tag0};
  assign push_ent[1] = '{is_fp: dec_is_fp[1], tag: dec_tag1};

  assign dec_ready = !flush && (free_slots(uint_t'(occ), DEPTH) >= 2);
  assign push_n    = dec_ready ? lane_count(dec_valid) : 2'd0;

  dispatch_slots #(.DEPTH(DEPTH)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .push_n   (push_n),
    .push_ent (push_ent),
    .pop_n    (pop_n),
    .view     (view),
    .view_vld (view_vld),
    .occ      (occ)
  );

  dispatch_pick #(.DEPTH(DEPTH)) u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .view        (view),
    .view_vld    (view_vld),
    .int_vld     (int_vld),
    .int_ent     (int_ent),
    .fp_vld      (fp_vld),
    .fp_ent      (fp_ent),
    .pop_n       (pop_n),
    .held_by_fp  (held_by_fp),
    .held_by_int (held_by_int)
  );

  assign int0_valid = int_vld[0];
  assign int0_tag   = int_ent[0].tag;
  assign int1_valid = int_vld[1];
  assign int1_tag   = int_ent[1].tag;
  assign fp_valid   = fp_vld;
  assign fp_tag     = fp_ent.tag;

  // R4
  property int_port_order_p;
    @(posedge clk) disable iff (!rst_n)
      int1_valid |-> int0_valid;
  endproperty
  int_port_order_chk: assert property (int_port_order_p);

  // R2
  property ready_means_room_p;
    @(posedge clk) disable iff (!rst_n)
      dec_ready |-> (uint_t'(occ) + 2 <= DEPTH);
  endproperty
  ready_means_room_chk: assert property (ready_means_room_p);

  // R7
  property flush_silences_p;
    @(posedge clk) disable iff (!rst_n)
      flush |-> (!dec_ready && !int0_valid && !fp_valid);
  endproperty
  flush_silences_chk: assert property (flush_silences_p);

endmodule

// File: tb/dual_issue_dispatch_tb.sv
module dual_issue_dispatch_tb;
  import dispatch_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             flush;
  logic [1:0]       dec_valid;
  logic [1:0]       dec_is_fp;
  logic [TAG_W-1:0] dec_tag0, dec_tag1;
  logic             dec_ready;
  logic             int0_valid, int1_valid, fp_valid;
  logic [TAG_W-1:0] int0_tag, int1_tag, fp_tag;

  int checks = 0;
  int errors = 0;

  bit               mq_fp[$];
  logic [TAG_W-1:0] mq_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_dispatch #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .dec_valid(dec_valid), .dec_is_fp(dec_is_fp),
    .dec_tag0(dec_tag0), .dec_tag1(dec_tag1), .dec_ready(dec_ready),
    .int0_valid(int0_valid), .int0_tag(int0_tag),
    .int1_valid(int1_valid), .int1_tag(int1_tag),
    .fp_valid(fp_valid), .fp_tag(fp_tag)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bench restatement of the issue rule: walk the model queue, stop at first miss
  function automatic int model_issue(output bit e_i0, output int t_i0,
                                     output bit e_i1, output int t_i1,
                                     output bit e_f,  output int t_f);
    int ni = 0;
    int n  = 0;
    e_i0 = 0; e_i1 = 0; e_f = 0; t_i0 = 0; t_i1 = 0; t_f = 0;
    if (flush) return 0;
    foreach (mq_fp[i]) begin
      if (!mq_fp[i] && ni == 0)      begin e_i0 = 1; t_i0 = mq_tag[i]; ni++; n++; end
      else if (!mq_fp[i] && ni == 1) begin e_i1 = 1; t_i1 = mq_tag[i]; ni++; n++; end
      else if (mq_fp[i] && !e_f)     begin e_f  = 1; t_f  = mq_tag[i]; n++; end
      else break;
    end
    return n;
  endfunction

  task automatic set_in(bit fl, logic [1:0] v, logic [1:0] f, int t0, int t1);
    @(negedge clk);
    flush = fl; dec_valid = v; dec_is_fp = f;
    dec_tag0 = TAG_W'(t0); dec_tag1 = TAG_W'(t1);
    #1;
  endtask

  // Compare the ports with the model, then advance the model across the edge
  task automatic commit(string req);
    bit e_i0, e_i1, e_f, e_rdy;
    int t_i0, t_i1, t_f, npop;
    npop  = model_issue(e_i0, t_i0, e_i1, t_i1, e_f, t_f);
    e_rdy = !flush && (DEPTH - mq_fp.size() >= 2);
    chk(req, "dec_ready", dec_ready, e_rdy);
    chk(req, "int0_valid", int0_valid, e_i0);
    chk(req, "int1_valid", int1_valid, e_i1);
    chk(req, "fp_valid", fp_valid, e_f);
    if (e_i0) chk(req, "int0_tag", int0_tag, t_i0);
    if (e_i1) chk(req, "int1_tag", int1_tag, t_i1);
    if (e_f)  chk(req, "fp_tag", fp_tag, t_f);
    if (flush) begin
      mq_fp.delete(); mq_tag.delete();
    end else begin
      for (int k = 0; k < npop; k++) begin
        void'(mq_fp.pop_front()); void'(mq_tag.pop_front());
      end
      if (e_rdy && dec_valid[0]) begin
        mq_fp.push_back(dec_is_fp[0]); mq_tag.push_back(dec_tag0);
        if (dec_valid[1]) begin
          mq_fp.push_back(dec_is_fp[1]); mq_tag.push_back(dec_tag1);
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int tag;
    void'($urandom(32'd2024));
    rst_n = 0; flush = 0; dec_valid = 0; dec_is_fp = 0; dec_tag0 = 0; dec_tag1 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    set_in(0, 2'b00, 2'b00, 0, 0);
    chk("R1", "dec_ready", dec_ready, 1);
    chk("R1", "any_valid", int0_valid | int1_valid | fp_valid, 0);
    commit("R1");

    // R5/R6: two FP together, then an integer pair
    set_in(0, 2'b11, 2'b11, 0, 1);
    chk("R6", "fp_valid_same_cycle", fp_valid, 0);
    commit("R6");
    set_in(0, 2'b11, 2'b00, 2, 3);
    chk("R6", "fp_tag", fp_tag, 0);
    chk("R5", "int0_valid_behind_fp", int0_valid, 0);
    commit("R5");
    set_in(0, 2'b00, 2'b00, 0, 0);
    chk("R5", "fp_tag", fp_tag, 1);
    chk("R4", "int0_tag", int0_tag, 2);
    chk("R4", "int1_tag", int1_tag, 3);
    commit("R4");

    // R2: backpressure with three held
    set_in(0, 2'b11, 2'b11, 10, 11);
    commit("R2");
    set_in(0, 2'b11, 2'b11, 12, 13);
    chk("R2", "dec_ready_two_free", dec_ready, 1);
    commit("R2");
    set_in(0, 2'b11, 2'b00, 14, 15);
    chk("R2", "dec_ready_one_free", dec_ready, 0);
    chk("R2", "fp_tag", fp_tag, 11);
    commit("R2");
    set_in(0, 2'b00, 2'b00, 0, 0);
    chk("R2", "fp_tag", fp_tag, 12);
    chk("R2", "refused_int0", int0_valid, 0);
    commit("R2");
    set_in(0, 2'b00, 2'b00, 0, 0);
    chk("R2", "refused_int0_last", int0_valid, 0);
    commit("R2");

    // R3: integer behind a second FP stays held
    set_in(0, 2'b11, 2'b11, 60, 61);
    commit("R3");
    set_in(0, 2'b11, 2'b01, 62, 63);
    commit("R3");
    set_in(0, 2'b00, 2'b00, 0, 0);
    chk("R3", "fp_tag", fp_tag, 61);
    chk("R3", "young_int_held", int0_valid, 0);
    commit("R3");
    set_in(0, 2'b00, 2'b00, 0, 0);
    chk("R3", "fp_tag", fp_tag, 62);
    chk("R3", "int0_tag", int0_tag, 63);
    commit("R3");

    // R8: lane 1 alone is dropped
    set_in(0, 2'b10, 2'b00, 20, 21);
    commit("R8");
    set_in(0, 2'b00, 2'b00, 0, 0);
    chk("R8", "any_valid", int0_valid | int1_valid | fp_valid, 0);
    commit("R8");

    // R7: flush
    set_in(0, 2'b11, 2'b10, 30, 31);
    commit("R7");
    set_in(1, 2'b11, 2'b00, 32, 33);
    chk("R7", "dec_ready", dec_ready, 0);
    chk("R7", "any_valid", int0_valid | int1_valid | fp_valid, 0);
    commit("R7");
    set_in(0, 2'b00, 2'b00, 0, 0);
    chk("R7", "empty_after", int0_valid | int1_valid | fp_valid, 0);
    chk("R7", "dec_ready_after", dec_ready, 1);
    commit("R7");

    // Mixed random traffic against the model (R3, R4, R5)
    tag = 100;
    for (int c = 0; c < 3000; c++) begin
      logic [1:0] v, f;
      int r;
      r = $urandom % 8;
      v = (r < 2) ? 2'b00 : (r == 2) ? 2'b01 : (r == 3) ? 2'b10 : 2'b11;
      f = {($urandom % 5) < 2, ($urandom % 5) < 2};
      set_in(($urandom % 50) == 0, v, f, tag, tag + 1);
      tag += 2;
      commit("R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule